// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns an asynchronous, active-low external interrupt pin into a latched interrupt request for a CPU. The pin goes through a two-flop synchronizer. A high-to-low transition of the synchronized level sets a request latch. A mode bit can add low-level sensitivity. In that mode the request is released only after an acknowledge has occurred and the pin has returned high, and these two events may come in either order. A mask bit hides the request from the CPU without losing it.

Software uses one status/control byte on a simple write-strobe bus with a combinational read port. The CPU's vector-fetch strobe acts as a hardware acknowledge. The synchronized pin level is also brought out so that branch-on-pin-level instructions can test it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: A falling edge of the synchronized pin sets the request latch, which reads back as bit 3 of `rd_data`. `irq_req` rises three clock edges after the raw pin falls.
- R2: With the mode bit (bit 0) at 0, the latch stays set when the pin returns high. It clears on a `vec_fetch` pulse or on a write that has bit 2 (acknowledge) set.
- R3: With the mode bit at 1, an acknowledge given while the pin is still low does not clear the latch. The latch clears once the pin is then seen high.
- R4: With the mode bit at 1, a pin that returns high before any acknowledge leaves the latch set. The next acknowledge then clears it.
- R5: Reset clears the latch, the mode bit and the mask bit. The request stays off after reset even if the pin is held low throughout.
- R6: While the mask bit (bit 1) is 1, `irq_req` is 0 and the latch flag still reads 1. Clearing the mask presents the request again.
- R7: `rd_data` bits 7..4 and bit 2 always read 0. Bits 1 and 0 read back the last values written.
- R8: When a falling edge and an acknowledge fall in the same cycle, the latch ends up set.
- R9: `pin_level` follows the raw pin after two clock edges.
- R10: Writes to bits 7..3 have no effect. In particular, writing bit 3 does not set the latch.
- R11: In edge-only mode, a pin held low after an acknowledge does not set the latch again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n | input | 1 | Raw asynchronous interrupt pin, active low |
| vec_fetch | input | 1 | One-cycle strobe from the CPU when it fetches this interrupt's vector |
| wr_en | input | 1 | Write strobe for the status/control byte |
| wr_data | input | 8 | Write data: bit 2 acknowledge, bit 1 mask, bit 0 mode |
| rd_data | output | 8 | Status/control read: bit 3 latch flag, bit 1 mask, bit 0 mode |
| irq_req | output | 1 | Masked interrupt request to the CPU |
| pin_level | output | 1 | Synchronized pin level |

## Verification
A new falling edge and an acknowledge can both land in the same cycle. The bench first latches one request and releases the pin. It then drops the pin again and times a write of the acknowledge bit so that the write occupies exactly the cycle in which the synchronized edge is detected. The outcome is judged at the ports: the latch flag and `irq_req` must still be 1 after that cycle, because setting has priority over clearing.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic       vec_fetch,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq_req,
  output logic       pin_level
);
  logic s1_q, s2_q, prev_q;
  logic latch_q, mode_q, mask_q, acked_q;
  logic fall, ack, lvl_clr, latch_d;

  wire unused_wr = &{1'b0, wr_data[7:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall    = prev_q & ~s2_q;
  assign ack     = vec_fetch | (wr_en & wr_data[2]);
  assign lvl_clr = (ack | acked_q) & s2_q;

  always_comb begin
    if (fall)        latch_d = 1'b1;
    else if (mode_q) latch_d = latch_q & ~lvl_clr;
    else             latch_d = latch_q & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      acked_q <= 1'b0;
      mode_q  <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      if (!mode_q || fall || !latch_d) acked_q <= 1'b0;
      else if (ack)                    acked_q <= 1'b1;
      if (wr_en) begin
        mask_q <= wr_data[1];
        mode_q <= wr_data[0];
      end
    end
  end

  assign rd_data   = {4'b0000, latch_q, 1'b0, mask_q, mode_q};
  assign irq_req   = latch_q & ~mask_q;
  assign pin_level = s2_q;
endmodule

module ext_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s2_q,
  input logic       prev_q,
  input logic       latch_q,
  input logic       mode_q,
  input logic       mask_q,
  input logic       ack,
  input logic [7:0] rd_data,
  input logic       irq_req
);
  // R1
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q && !s2_q) |=> latch_q);
  // R2
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && latch_q && !ack) |=> latch_q);
  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && latch_q && !s2_q) |=> latch_q);
  // R6
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_req);
  // R7
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:4] == 4'd0) && !rd_data[2]);
  // R11
  no_reset_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_q && !(prev_q && !s2_q)) |=> !latch_q);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s2_q(s2_q), .prev_q(prev_q),
  .latch_q(latch_q), .mode_q(mode_q), .mask_q(mask_q), .ack(ack),
  .rd_data(rd_data), .irq_req(irq_req)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic clk = 0, rst_n = 0, pin_n = 1, vec_fetch = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic irq_req, pin_level;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .pin_n(pin_n), .vec_fetch(vec_fetch),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req),
    .pin_level(pin_level));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic vf();
    vec_fetch = 1; @(negedge clk); vec_fetch = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; pin_n = 1; cyc(2);
    chk("R5 reset rd", rd_data, 0);
    chk("R5 reset irq", irq_req, 0);
    rst_n = 1; cyc(3);
    chk("R9 idle level", pin_level, 1);
  endtask

  task automatic t_sync_edge();
    pin_n = 0; cyc(1);
    chk("R9 one edge", pin_level, 1);
    cyc(1);
    chk("R9 two edges", pin_level, 0);
    chk("R1 not yet", irq_req, 0);
    cyc(1);
    chk("R1 irq", irq_req, 1);
    chk("R1 flag", rd_data[3], 1);
  endtask

  task automatic t_edge_mode();
    pin_n = 1; cyc(3);
    chk("R2 pin high holds", rd_data[3], 1);
    vf();
    chk("R2 vec clear", rd_data[3], 0);
    pin_n = 0; cyc(3);
    chk("R2 reset latch", irq_req, 1);
    wr(8'h04);
    chk("R2 ack clear", rd_data[3], 0);
    cyc(4);
    chk("R11 low no reset", rd_data[3], 0);
    pin_n = 1; cyc(3);
  endtask

  task automatic t_level_ack_first();
    wr(8'h01);
    pin_n = 0; cyc(3);
    chk("R3 latched", rd_data[3], 1);
    wr(8'h05); cyc(2);
    chk("R3 low holds", rd_data[3], 1);
    pin_n = 1; cyc(2);
    chk("R3 not yet", rd_data[3], 1);
    cyc(1);
    chk("R3 cleared", rd_data[3], 0);
  endtask

  task automatic t_level_high_first();
    pin_n = 0; cyc(3);
    chk("R4 latched", rd_data[3], 1);
    pin_n = 1; cyc(4);
    chk("R4 high holds", rd_data[3], 1);
    vf();
    chk("R4 cleared", rd_data[3], 0);
    wr(8'h00);
  endtask

  task automatic t_mask();
    pin_n = 0; cyc(3); pin_n = 1; cyc(3);
    wr(8'h02);
    chk("R6 masked irq", irq_req, 0);
    chk("R6 flag kept", rd_data[3], 1);
    chk("R7 readback", rd_data, 8'h0A);
    wr(8'h00);
    chk("R6 unmasked", irq_req, 1);
    wr(8'h04);
    chk("R6 cleared", rd_data, 0);
  endtask

  task automatic t_collide();
    pin_n = 0; cyc(3); pin_n = 1; cyc(3);
    chk("R8 pre", rd_data[3], 1);
    pin_n = 0; cyc(2);
    wr(8'h04);
    chk("R8 set wins", rd_data[3], 1);
    chk("R8 irq", irq_req, 1);
    wr(8'h04);
    chk("R8 later clear", rd_data[3], 0);
    pin_n = 1; cyc(3);
  endtask

  task automatic t_ignored();
    wr(8'hF8);
    chk("R10 ignored", rd_data, 0);
    chk("R10 irq", irq_req, 0);
  endtask

  task automatic t_reset_low();
    wr(8'h03);
    pin_n = 0; cyc(3);
    chk("R5 pre flag", rd_data, 8'h0B);
    rst_n = 0; cyc(2); rst_n = 1; cyc(5);
    chk("R5 after reset", rd_data, 0);
    chk("R5 irq low pin", irq_req, 0);
    pin_n = 1; cyc(3);
  endtask

  initial begin
    t_reset();
    t_sync_edge();
    t_edge_mode();
    t_level_ack_first();
    t_level_high_first();
    t_mask();
    t_collide();
    t_ignored();
    t_reset_low();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule